// File: doc/BRIEF.md
# Page-Load Write Controller

This block sits behind a parallel memory-style host bus and turns bus write strobes into page programming operations. Write strobes use active-low chip-select, write-strobe and read-enable lines. Every strobe that qualifies deposits one byte into a page buffer of 64 bytes. A per-byte valid mask records which offsets were written. A load window timer is restarted by every completed strobe and paused while a strobe is in progress. When the window closes with no further strobe, the controller enters a self-timed programming interval. At the end of that interval it presents the page number, the valid mask and the buffered bytes to the array for one clock cycle.

All bus lines are sampled on the system clock, and every duration is a parameter counted in clock cycles. The block holds off all writes for a fixed interval after reset. It also rejects strobes that are too narrow or that arrive while a programming interval is running. The array model on the far side must update only the offsets whose mask bit is set.

Top module: `page_load_ctrl`

## Requirements
- R1: A strobe exists only while `bus_cs_n` and `bus_wr_n` are both low and `bus_rd_n` is high. With `bus_rd_n` low, or with only one of the other two low, no byte is loaded.
- R2: The address is sampled when the later of `bus_wr_n` / `bus_cs_n` falls. The data is the value present in the last sampled cycle before the earlier of the two rises. Address or data changes outside the strobe have no effect.
- R3: Address bits [5:0] choose the byte offset inside the page, and bytes may arrive in any order. `commit_page` equals address bits [14:6] of the last accepted strobe.
- R4: The load window restarts on every strobe release. A programming interval begins only after LOAD_CYC clock cycles pass with no strobe. The commit pulse follows the last release by LOAD_CYC+PROG_CYC+2 cycles.
- R5: At commit, bit i of `commit_mask` is 1 exactly when offset i was loaded. `commit_data[8*i+7:8*i]` holds the last byte loaded at offset i.
- R6: `busy` is high for the PROG_CYC programming cycles and for the commit cycle. `commit_valid` is a single-cycle pulse.
- R7: A strobe held active for fewer than MIN_PULSE sampled cycles loads nothing.
- R8: Strobes while `busy` is high are ignored. The mask and data do not change, and no later commit results from them.
- R9: In the cycle after `commit_valid`, `commit_mask` is all zeros.
- R10: For INIT_CYC cycles after reset release, strobes load nothing and cause no commit.
- R11: After reset, `busy`, `commit_valid` and `commit_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read enable, active low; low blocks writes |
| bus_addr | input | 15 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| busy | output | 1 | Programming interval or commit in progress |
| commit_valid | output | 1 | One-cycle commit pulse to the array |
| commit_page | output | 9 | Page number of the commit |
| commit_mask | output | 64 | Per-offset valid bits |
| commit_data | output | 512 | Buffered page bytes, offset i at bits 8i+7:8i |

## Verification
The bound checker watches, on every clock cycle, the properties that can be read from the output ports alone. It checks that the commit pulse lasts one cycle and never carries an empty mask. It checks that the mask clears right after a commit, that mask and data are frozen while programming runs, that `busy` drops only after a commit, and that nothing is loaded during the post-reset hold-off. The directed scenarios cover the rest: capture of address and data on the correct strobe edge, the read-enable and narrow-pulse rejections, retriggering of the load window over a long out-of-order sequence, the page taken from the final strobe, and the exact commit latency.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOAD = 2'd2,
    ST_PROG = 2'd3
  } pwc_state_e;

  function automatic int unsigned pwc_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pwc_strobe.sv
module pwc_strobe #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              active,
  output logic              byte_ev,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [DATA_W-1:0] byte_data
);
  localparam int W_CNT = $clog2(MIN_PULSE + 1) + 1;
  localparam logic [W_CNT-1:0] MIN_C = W_CNT'(MIN_PULSE);

  logic              act_q, act_d;
  logic [ADDR_W-1:0] addr_q, addr_lat, addr_lat_nx;
  logic [DATA_W-1:0] data_q, data_lat, data_lat_nx;
  logic [W_CNT-1:0]  wcnt, wcnt_nx;
  logic              raw_act, rise, fall;

  assign raw_act = ~cs_n & ~wr_n & rd_n;
  assign rise    = act_q & ~act_d;
  assign fall    = ~act_q & act_d;

  always_comb begin
    addr_lat_nx = addr_lat;
    data_lat_nx = data_lat;
    wcnt_nx     = wcnt;
    if (rise) begin
      addr_lat_nx = addr_q;
      wcnt_nx     = W_CNT'(1);
    end else if (act_q && (wcnt < MIN_C)) begin
      wcnt_nx = wcnt + W_CNT'(1);
    end
    if (act_q) data_lat_nx = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      act_d    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      addr_lat <= '0;
      data_lat <= '0;
      wcnt     <= '0;
    end else begin
      act_q    <= raw_act;
      act_d    <= act_q;
      addr_q   <= addr;
      data_q   <= wdata;
      addr_lat <= addr_lat_nx;
      data_lat <= data_lat_nx;
      wcnt     <= wcnt_nx;
    end
  end

  assign active    = act_q;
  assign byte_ev   = fall & (wcnt >= MIN_C);
  assign byte_addr = addr_lat;
  assign byte_data = data_lat;
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int OFF_W  = 6,
  parameter int PAGE_W = 9,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            clr,
  input  logic [OFF_W-1:0]                offset,
  input  logic [PAGE_W-1:0]               page_in,
  input  logic [DATA_W-1:0]               wdata,
  output logic [(1<<OFF_W)-1:0]           mask,
  output logic [(1<<OFF_W)*DATA_W-1:0]    data_flat,
  output logic [PAGE_W-1:0]               page
);
  localparam int NBYTES = 1 << OFF_W;

  logic [PAGE_W-1:0] page_nx;

  always_comb begin
    page_nx = page;
    if (wr_en) page_nx = page_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= '0;
    else        page <= page_nx;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic              sel;
    logic              vld_nx;
    logic [DATA_W-1:0] byte_nx;

    assign sel = wr_en && (offset == OFF_W'(i));

    always_comb begin
      vld_nx  = mask[i];
      byte_nx = data_flat[i*DATA_W +: DATA_W];
      if (clr) vld_nx = 1'b0;
      else if (sel) begin
        vld_nx  = 1'b1;
        byte_nx = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[i]                      <= 1'b0;
        data_flat[i*DATA_W +: DATA_W] <= '0;
      end else begin
        mask[i]                      <= vld_nx;
        data_flat[i*DATA_W +: DATA_W] <= byte_nx;
      end
    end
  end
endmodule

// File: rtl/pwc_seq.sv
module pwc_seq
  import pwc_pkg::*;
#(
  parameter int INIT_CYC = 16,
  parameter int LOAD_CYC = 32,
  parameter int PROG_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_ev,
  input  logic active,
  output logic buf_we,
  output logic buf_clr,
  output logic busy,
  output logic commit_valid
);
  localparam int unsigned CMAX = pwc_max3(INIT_CYC, LOAD_CYC, PROG_CYC);
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_END = CNT_W'(PROG_CYC - 1);

  pwc_state_e       state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             cv_q, cv_nx;
  logic             accept;

  assign accept = byte_ev && !cv_q && ((state == ST_IDLE) || (state == ST_LOAD));

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    cv_nx    = 1'b0;
    unique case (state)
      ST_HOLD: begin
        if (cnt == INIT_END) begin
          state_nx = ST_IDLE;
          cnt_nx   = '0;
        end else cnt_nx = cnt + CNT_W'(1);
      end
      ST_IDLE: begin
        if (accept) begin
          state_nx = ST_LOAD;
          cnt_nx   = '0;
        end
      end
      ST_LOAD: begin
        if (accept || active) cnt_nx = '0;
        else if (cnt == LOAD_END) begin
          state_nx = ST_PROG;
          cnt_nx   = '0;
        end else cnt_nx = cnt + CNT_W'(1);
      end
      ST_PROG: begin
        if (cnt == PROG_END) begin
          state_nx = ST_IDLE;
          cnt_nx   = '0;
          cv_nx    = 1'b1;
        end else cnt_nx = cnt + CNT_W'(1);
      end
      default: state_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      cnt   <= '0;
      cv_q  <= 1'b0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
      cv_q  <= cv_nx;
    end
  end

  assign buf_we       = accept;
  assign buf_clr      = cv_q;
  assign busy         = (state == ST_PROG) || cv_q;
  assign commit_valid = cv_q;
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 6,
  parameter int INIT_CYC  = 16,
  parameter int LOAD_CYC  = 32,
  parameter int PROG_CYC  = 64,
  parameter int MIN_PULSE = 3,
  localparam int NBYTES   = 1 << OFF_W,
  localparam int PAGE_W   = ADDR_W - OFF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_cs_n,
  input  logic                     bus_wr_n,
  input  logic                     bus_rd_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic                     busy,
  output logic                     commit_valid,
  output logic [PAGE_W-1:0]        commit_page,
  output logic [NBYTES-1:0]        commit_mask,
  output logic [NBYTES*DATA_W-1:0] commit_data
);
  logic [1:0]        rst_sync;
  logic              srst_n;
  logic              active, byte_ev, buf_we, buf_clr;
  logic [ADDR_W-1:0] byte_addr;
  logic [DATA_W-1:0] byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  pwc_strobe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_strobe (
    .clk(clk), .rst_n(srst_n),
    .cs_n(bus_cs_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n),
    .addr(bus_addr), .wdata(bus_wdata),
    .active(active), .byte_ev(byte_ev),
    .byte_addr(byte_addr), .byte_data(byte_data)
  );

  pwc_seq #(
    .INIT_CYC(INIT_CYC), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(srst_n),
    .byte_ev(byte_ev), .active(active),
    .buf_we(buf_we), .buf_clr(buf_clr),
    .busy(busy), .commit_valid(commit_valid)
  );

  pwc_page_buf #(
    .OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) u_buf (
    .clk(clk), .rst_n(srst_n),
    .wr_en(buf_we), .clr(buf_clr),
    .offset(byte_addr[OFF_W-1:0]),
    .page_in(byte_addr[ADDR_W-1:OFF_W]),
    .wdata(byte_data),
    .mask(commit_mask), .data_flat(commit_data), .page(commit_page)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int NBYTES   = 64,
  parameter int DATA_W   = 8,
  parameter int INIT_CYC = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     commit_valid,
  input logic [NBYTES-1:0]        commit_mask,
  input logic [NBYTES*DATA_W-1:0] commit_data
);
  localparam int IW = $clog2(INIT_CYC + 1) + 1;
  logic [IW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < IW'(INIT_CYC)) since_rst <= since_rst + IW'(1);
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit_valid));

  p_commit_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> (commit_mask != '0));

  p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> (commit_mask == '0));

  p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_valid) |=> ($stable(commit_mask) && $stable(commit_data)));

  p_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < IW'(INIT_CYC)) |-> (commit_mask == '0));
endmodule

bind page_load_ctrl pwc_checker #(
  .NBYTES(NBYTES), .DATA_W(DATA_W), .INIT_CYC(INIT_CYC)
) u_pwc_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit_valid(commit_valid),
  .commit_mask(commit_mask), .commit_data(commit_data)
);

// File: tb/tb_page_load_ctrl.sv
`timescale 1ns/1ps
module tb_page_load_ctrl;
  localparam int INIT_CYC = 16, LOAD_CYC = 32, PROG_CYC = 64, MIN_PULSE = 3;
  localparam int LAT = LOAD_CYC + PROG_CYC + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic busy, commit_valid;
  logic [8:0]   commit_page;
  logic [63:0]  commit_mask;
  logic [511:0] commit_data;

  int checks = 0, fails = 0, cyc = 0, cap_cnt = 0, cap_cyc = 0, rel_cyc = 0, busy_cyc = 0;
  bit done = 0;
  logic [8:0]   cap_page;
  logic [63:0]  cap_mask;
  logic [511:0] cap_data;

  always #4 clk = ~clk;

  page_load_ctrl #(.INIT_CYC(INIT_CYC), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC),
                   .MIN_PULSE(MIN_PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
    .bus_addr(addr), .bus_wdata(wdata), .busy(busy), .commit_valid(commit_valid),
    .commit_page(commit_page), .commit_mask(commit_mask), .commit_data(commit_data));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (busy) busy_cyc <= busy_cyc + 1;
    if (commit_valid) begin
      cap_cnt  <= cap_cnt + 1;
      cap_cyc  <= cyc;
      cap_page <= commit_page;
      cap_mask <= commit_mask;
      cap_data <= commit_data;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input int w);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (w) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; wdata = ~d;
    rel_cyc = cyc;
  endtask

  task automatic wait_commit(input int prev);
    for (int i = 0; i < 1000 && cap_cnt == prev; i++) @(negedge clk);
    idle(1);
  endtask

  task automatic t_reset;
    idle(1);
    check(busy == 1'b0, "R11 busy", 64'(busy), 0);
    check(commit_valid == 1'b0, "R11 commit_valid", 64'(commit_valid), 0);
    check(commit_mask == '0, "R11 mask", commit_mask, 0);
    wr(15'h0011, 8'h77, 3);
    idle(LAT + 20);
    check(cap_cnt == 0, "R10 no commit in hold-off", 64'(cap_cnt), 0);
    check(commit_mask == '0, "R10 nothing loaded", commit_mask, 0);
  endtask

  task automatic t_single;
    int prev = cap_cnt;
    int b0 = busy_cyc;
    wr(15'h1234, 8'hA5, 3);
    wait_commit(prev);
    check(cap_cnt == prev + 1, "R6 one commit", 64'(cap_cnt), 64'(prev + 1));
    check(cap_mask == (64'd1 << 6'h34), "R5 mask", cap_mask, 64'd1 << 6'h34);
    check(cap_data[8*6'h34 +: 8] == 8'hA5, "R5 data", 64'(cap_data[8*6'h34 +: 8]), 64'hA5);
    check(cap_page == 9'h048, "R3 page", 64'(cap_page), 64'h48);
    check(cap_cyc - rel_cyc == LAT, "R4 latency", 64'(cap_cyc - rel_cyc), 64'(LAT));
    check(busy_cyc - b0 == PROG_CYC + 1, "R6 busy length", 64'(busy_cyc - b0), 64'(PROG_CYC + 1));
    idle(3);
    check(commit_mask == '0, "R9 mask cleared", commit_mask, 0);
    check(busy == 1'b0, "R6 busy low after", 64'(busy), 0);
    check(cap_cnt == prev + 1, "R6 single pulse", 64'(cap_cnt), 64'(prev + 1));
  endtask

  task automatic t_page;
    int prev = cap_cnt;
    logic [63:0] em = '0;
    bit ok = 1;
    logic [5:0] offs [6] = '{6'd63, 6'd0, 6'd17, 6'd5, 6'd17, 6'd40};
    logic [8:0] pgs  [6] = '{9'h1FF, 9'h003, 9'h100, 9'h055, 9'h0AA, 9'h12C};
    logic [7:0] exp_b [64];
    for (int k = 0; k < 6; k++) begin
      wr({pgs[k], offs[k]}, 8'(8'h30 + k), 3 + k);
      em[offs[k]] = 1'b1;
      exp_b[offs[k]] = 8'(8'h30 + k);
      idle(LOAD_CYC - 12);
      check(cap_cnt == prev, "R4 window retriggered", 64'(cap_cnt), 64'(prev));
    end
    wait_commit(prev);
    check(cap_mask == em, "R5 out-of-order mask", cap_mask, em);
    for (int i = 0; i < 64; i++)
      if (em[i] && cap_data[8*i +: 8] != exp_b[i]) ok = 0;
    check(ok, "R5 last byte per offset", 64'(ok), 1);
    check(cap_page == 9'h12C, "R3 page from last strobe", 64'(cap_page), 64'h12C);
    check(cap_cyc - rel_cyc == LAT, "R4 latency after last", 64'(cap_cyc - rel_cyc), 64'(LAT));
    idle(4);
  endtask

  task automatic t_capture;
    int prev = cap_cnt;
    @(negedge clk); addr = 15'h0101; wdata = 8'h11; cs_n = 1'b0;
    idle(2); addr = 15'h0207;
    idle(1); wr_n = 1'b0;
    idle(1); addr = 15'h7FFF;
    idle(3); wr_n = 1'b1; wdata = 8'hEE; addr = 15'h0302;
    idle(2); cs_n = 1'b1;
    rel_cyc = cyc;
    idle(6);
    @(negedge clk); addr = 15'h0A09; wdata = 8'h5C; wr_n = 1'b0;
    idle(2); cs_n = 1'b0;
    idle(1); addr = 15'h0000;
    idle(3); cs_n = 1'b1; wdata = 8'h00;
    idle(2); wr_n = 1'b1;
    wait_commit(prev);
    check(cap_mask == ((64'd1 << 7) | (64'd1 << 9)), "R2 address at later fall", cap_mask,
          (64'd1 << 7) | (64'd1 << 9));
    check(cap_data[8*7 +: 8] == 8'h11, "R2 data before write-strobe rise", 64'(cap_data[8*7 +: 8]), 64'h11);
    check(cap_data[8*9 +: 8] == 8'h5C, "R2 data before select rise", 64'(cap_data[8*9 +: 8]), 64'h5C);
    check(cap_page == 9'h028, "R2 page of select-timed strobe", 64'(cap_page), 64'h28);
    idle(4);
  endtask

  task automatic t_inhibit;
    int prev = cap_cnt;
    rd_n = 1'b0;
    wr(15'h0042, 8'h99, 5);
    rd_n = 1'b1;
    @(negedge clk); addr = 15'h0043; wr_n = 1'b0; idle(5); wr_n = 1'b1;
    @(negedge clk); addr = 15'h0044; cs_n = 1'b0; idle(5); cs_n = 1'b1;
    idle(LAT + 20);
    check(cap_cnt == prev, "R1 inhibited strobes", 64'(cap_cnt), 64'(prev));
    check(commit_mask == '0, "R1 nothing loaded", commit_mask, 0);
    wr(15'h0045, 8'h01, MIN_PULSE - 1);
    idle(LAT + 20);
    check(cap_cnt == prev, "R7 narrow pulse alone", 64'(cap_cnt), 64'(prev));
    wr(15'h0046, 8'h02, MIN_PULSE);
    idle(4);
    wr(15'h0047, 8'h03, MIN_PULSE - 1);
    wait_commit(prev);
    check(cap_mask == (64'd1 << 6), "R7 narrow pulse in sequence", cap_mask, 64'd1 << 6);
    idle(4);
  endtask

  task automatic t_busy;
    int prev = cap_cnt;
    wr(15'h2010, 8'hC3, 3);
    for (int i = 0; i < 500 && !busy; i++) @(negedge clk);
    wr(15'h2011, 8'h3C, 4);
    idle(4);
    wr(15'h2012, 8'h3D, 4);
    wait_commit(prev);
    check(cap_mask == (64'd1 << 16), "R8 busy strobes ignored", cap_mask, 64'd1 << 16);
    check(cap_data[8*16 +: 8] == 8'hC3, "R8 data kept", 64'(cap_data[8*16 +: 8]), 64'hC3);
    idle(LAT + 20);
    check(cap_cnt == prev + 1, "R8 no later commit", 64'(cap_cnt), 64'(prev + 1));
    check(commit_mask == '0, "R9 empty after busy test", commit_mask, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_page();
    t_capture();
    t_inhibit();
    t_busy();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule